// File: doc/BRIEF.md
# Capability Control Register Bank

This block holds the per-privilege control registers of a processor capability extension and serves the register accesses aimed at them. The core presents a 12-bit register address, its current privilege level, a read strobe, a write strobe and an XLEN-wide write value. In the same cycle the block answers with the read value, an illegal-access flag and the value that a write leaves in storage. The stored value changes on the next rising clock edge.

Two physical registers exist: one for user level and one for supervisor level. The machine-level address has no storage of its own. It is a second window onto the supervisor register. Each register has two defined control bits, an enable bit and a disable-control bit. Every write goes through a legalizer that drives both defined bits to one. The write also leaves the undefined bits at their old value. Whether an address exists depends on which privilege modes are built in, set by parameters, and on the current privilege. An access to an address that does not exist is flagged and has no other effect.

Top module: `cap_csr_bank`

## Requirements
- R1: Address 0x8C0 selects the user register and 0x9C0 selects the supervisor register. A defined read returns the selected register on `rd_data` in the same cycle. With no read strobe, `rd_data` is zero.
- R2: Address 0xBC0 has no storage of its own. Its reads return the supervisor register, and its writes update the supervisor register.
- R3: The enable bit sits at bit 0 and the disable-control bit at bit 1. After reset both registers hold 0x3, with all other bits zero.
- R4: A defined write stores a value with bits 1 and 0 both set, whatever is written. `wr_result` shows that value in the write cycle.
- R5: On a write, bits XLEN-1..2 keep their previous value. Writing all ones does not set them.
- R6: The value shown on `wr_result` is the value a read of the same register returns from the following cycle on.
- R7: Address 0x8C0 is defined at every privilege when user mode is built in (`HAVE_USER`=1).
- R8: Address 0x9C0 is defined only when supervisor mode is built in and the privilege is Machine (2'd3) or Supervisor (2'd1). It is undefined at User (2'd0) and at the reserved code 2'd2.
- R9: Address 0xBC0 is defined only when supervisor mode is built in and the privilege is Machine (2'd3).
- R10: When a read or write strobe is active and the access is undefined, `illegal` is 1 in that cycle, `rd_data` and `wr_result` are zero, and no register changes. Every address other than the three above is undefined. With no strobe, `illegal` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| csr_addr | input | 12 | Register address of the access |
| cur_priv | input | 2 | Current privilege: 0 User, 1 Supervisor, 3 Machine |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wr_data | input | XLEN | Value offered by a write |
| rd_data | output | XLEN | Read value, zero unless a defined read |
| illegal | output | 1 | Strobed access to an undefined address |
| wr_result | output | XLEN | Legalized value a defined write stores |

## Verification
The `rd_data`, `illegal` and `wr_result` outputs are combinational, so each one is due in the same cycle as the strobe that causes it. A write reaches storage at the next rising edge, so its effect becomes visible to a read issued one cycle later. The driver applies each access just after a falling edge and queues the expected results. The monitor compares them one time unit later, before the rising edge that would commit the write. Back-to-back accesses therefore check both the same-cycle outputs and the contents left by the previous write.

// File: rtl/cap_csr_pkg.sv
package cap_csr_pkg;

  typedef enum logic [1:0] {
    PRIV_USR = 2'd0,
    PRIV_SUP = 2'd1,
    PRIV_RSV = 2'd2,
    PRIV_MCH = 2'd3
  } priv_e;

  typedef enum logic [1:0] {
    TGT_NONE = 2'd0,
    TGT_USR  = 2'd1,
    TGT_SUP  = 2'd2
  } tgt_e;

  localparam logic [11:0] ADDR_USR_CTL = 12'h8C0;
  localparam logic [11:0] ADDR_SUP_CTL = 12'h9C0;
  localparam logic [11:0] ADDR_MCH_CTL = 12'hBC0;

  localparam int POS_EN  = 0;
  localparam int POS_DIS = 1;
  localparam int NUM_REGS = 2;

  // Defined bits a write may take from software (before forcing)
  function automatic logic [1:0] field_mask();
    logic [1:0] m;
    m = '0;
    m[POS_EN]  = 1'b1;
    m[POS_DIS] = 1'b1;
    return m;
  endfunction

  // Defined bits hardwired to one for a write made through a given window
  function automatic logic [1:0] forced_ones(priv_e p);
    logic [1:0] m;
    case (p)
      PRIV_USR: m = 2'b11;
      PRIV_SUP: m = 2'b11;
      PRIV_MCH: m = 2'b11;
      default:  m = 2'b11;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/cap_csr_decode.sv
module cap_csr_decode
  import cap_csr_pkg::*;
#(
  parameter bit HAVE_USER  = 1'b1,
  parameter bit HAVE_SUPER = 1'b1
) (
  input  logic [11:0] addr,
  input  priv_e       cur_priv,
  output tgt_e        target,
  output priv_e       win_priv,
  output logic        defined
);

  logic priv_ms;
  logic priv_m;

  assign priv_ms = (cur_priv == PRIV_MCH) || (cur_priv == PRIV_SUP);
  assign priv_m  = (cur_priv == PRIV_MCH);

  always_comb begin
    target   = TGT_NONE;
    win_priv = PRIV_USR;
    defined  = 1'b0;
    case (addr)
      ADDR_USR_CTL: begin
        target   = TGT_USR;
        win_priv = PRIV_USR;
        defined  = HAVE_USER;
      end
      ADDR_SUP_CTL: begin
        target   = TGT_SUP;
        win_priv = PRIV_SUP;
        defined  = HAVE_SUPER && priv_ms;
      end
      ADDR_MCH_CTL: begin
        target   = TGT_SUP;
        win_priv = PRIV_MCH;
        defined  = HAVE_SUPER && priv_m;
      end
      default: begin
        target   = TGT_NONE;
        win_priv = PRIV_USR;
        defined  = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/cap_csr_reg.sv
module cap_csr_reg
  import cap_csr_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  priv_e           win_priv,
  input  logic [XLEN-1:0] wdata,
  output logic [XLEN-1:0] q,
  output logic [XLEN-1:0] q_next
);

  localparam logic [XLEN-1:0] DEF_MASK = XLEN'(field_mask());
  localparam logic [XLEN-1:0] RST_VAL  = DEF_MASK;

  function automatic logic [XLEN-1:0] legalize(
    input priv_e           p,
    input logic [XLEN-1:0] old_v,
    input logic [XLEN-1:0] new_v
  );
    logic [XLEN-1:0] r;
    r = (old_v & ~DEF_MASK) | (new_v & DEF_MASK);
    r = r | XLEN'(forced_ones(p));
    return r;
  endfunction

  assign q_next = legalize(win_priv, q, wdata);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= RST_VAL;
    else if (we) q <= q_next;
  end

endmodule

// File: rtl/cap_csr_bank.sv
module cap_csr_bank
  import cap_csr_pkg::*;
#(
  parameter int XLEN       = 64,
  parameter bit HAVE_USER  = 1'b1,
  parameter bit HAVE_SUPER = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [11:0]     csr_addr,
  input  logic [1:0]      cur_priv,
  input  logic            rd_en,
  input  logic            wr_en,
  input  logic [XLEN-1:0] wr_data,
  output logic [XLEN-1:0] rd_data,
  output logic            illegal,
  output logic [XLEN-1:0] wr_result
);

  localparam int IDX_USR = 0;
  localparam int IDX_SUP = 1;

  tgt_e  target;
  priv_e win_priv;
  logic  acc_defined;
  logic  strobe;
  logic  rd_ok;
  logic  wr_ok;
  logic  sel_sup;

  logic [XLEN-1:0] reg_q  [NUM_REGS];
  logic [XLEN-1:0] reg_nx [NUM_REGS];
  logic [NUM_REGS-1:0] reg_we;

  // Named internal views used by the checker
  logic [XLEN-1:0] usr_q;
  logic [XLEN-1:0] sup_q;
  logic [XLEN-1:0] sel_q;
  logic [XLEN-1:0] sel_nx;

  cap_csr_decode #(
    .HAVE_USER (HAVE_USER),
    .HAVE_SUPER(HAVE_SUPER)
  ) dec_i (
    .addr    (csr_addr),
    .cur_priv(priv_e'(cur_priv)),
    .target  (target),
    .win_priv(win_priv),
    .defined (acc_defined)
  );

  assign strobe  = rd_en | wr_en;
  assign rd_ok   = rd_en & acc_defined;
  assign wr_ok   = wr_en & acc_defined;
  assign sel_sup = (target == TGT_SUP);

  generate
    for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_reg
      localparam tgt_e MY_TGT = (gi == IDX_USR) ? TGT_USR : TGT_SUP;
      assign reg_we[gi] = wr_ok && (target == MY_TGT);
      cap_csr_reg #(.XLEN(XLEN)) reg_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (reg_we[gi]),
        .win_priv(win_priv),
        .wdata   (wr_data),
        .q       (reg_q[gi]),
        .q_next  (reg_nx[gi])
      );
    end
  endgenerate

  assign usr_q  = reg_q[IDX_USR];
  assign sup_q  = reg_q[IDX_SUP];
  assign sel_q  = sel_sup ? reg_q[IDX_SUP]  : reg_q[IDX_USR];
  assign sel_nx = sel_sup ? reg_nx[IDX_SUP] : reg_nx[IDX_USR];

  assign illegal   = strobe & ~acc_defined;
  assign rd_data   = rd_ok ? sel_q  : '0;
  assign wr_result = wr_ok ? sel_nx : '0;

endmodule

// File: rtl/cap_csr_bank_chk.sv
module cap_csr_bank_chk #(
  parameter int XLEN       = 64,
  parameter bit HAVE_USER  = 1'b1,
  parameter bit HAVE_SUPER = 1'b1
) (
  input logic            clk,
  input logic            rst_n,
  input logic [11:0]     csr_addr,
  input logic [1:0]      cur_priv,
  input logic            rd_en,
  input logic            wr_en,
  input logic            illegal,
  input logic [XLEN-1:0] rd_data,
  input logic [XLEN-1:0] wr_result,
  input logic [XLEN-1:0] usr_q,
  input logic [XLEN-1:0] sup_q
);

  // R2: machine window reads the supervisor storage
  a_r2_alias_read: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !illegal && csr_addr == 12'hBC0) |-> (rd_data == sup_q));

  // R2: machine window writes land in supervisor storage
  a_r2_alias_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !illegal && csr_addr == 12'hBC0) |=> (sup_q == $past(wr_result)));

  // R4: defined bits forced to one on a write
  a_r4_forced: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !illegal) |-> (wr_result[1:0] == 2'b11));

  // R5: undefined bits keep their old value
  a_r5_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !illegal) |->
      (wr_result[XLEN-1:2] == ((csr_addr == 12'h8C0) ? usr_q[XLEN-1:2] : sup_q[XLEN-1:2])));

  // R6: user write result becomes the stored value
  a_r6_store: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !illegal && csr_addr == 12'h8C0) |=> (usr_q == $past(wr_result)));

  // R7: user address exists when user mode is built in
  a_r7_user_def: assert property (@(posedge clk) disable iff (!rst_n)
    (HAVE_USER && (rd_en || wr_en) && csr_addr == 12'h8C0) |-> !illegal);

  // R8: supervisor address refused at user privilege
  a_r8_sup_user: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_en || wr_en) && csr_addr == 12'h9C0 && cur_priv == 2'd0) |-> illegal);

  // R9: machine window refused below machine privilege
  a_r9_mch_priv: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_en || wr_en) && csr_addr == 12'hBC0 && cur_priv != 2'd3) |-> illegal);

  // R10: illegal access returns zeros
  a_r10_zero: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (rd_data == '0 && wr_result == '0));

  // R10: illegal access changes no storage
  a_r10_nochange: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |=> ($stable(usr_q) && $stable(sup_q)));

  // R10: no strobe, no flag
  a_r10_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en || wr_en) |-> !illegal);

endmodule

bind cap_csr_bank cap_csr_bank_chk #(
  .XLEN      (XLEN),
  .HAVE_USER (HAVE_USER),
  .HAVE_SUPER(HAVE_SUPER)
) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .csr_addr (csr_addr),
  .cur_priv (cur_priv),
  .rd_en    (rd_en),
  .wr_en    (wr_en),
  .illegal  (illegal),
  .rd_data  (rd_data),
  .wr_result(wr_result),
  .usr_q    (usr_q),
  .sup_q    (sup_q)
);

// File: tb/cap_csr_bank_tb_top.sv
`timescale 1ns/1ps
module cap_csr_bank_tb_top;

  localparam int XLEN = 64;
  localparam logic [1:0] PU = 2'd0, PS = 2'd1, PR = 2'd2, PM = 2'd3;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [11:0]     csr_addr = '0;
  logic [1:0]      cur_priv = PM;
  logic            rd_en = 1'b0;
  logic            wr_en = 1'b0;
  logic [XLEN-1:0] wr_data = '0;
  logic [XLEN-1:0] rd_data;
  logic            illegal;
  logic [XLEN-1:0] wr_result;

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;

  // Scoreboard queues (parallel)
  string           q_tag [$];
  logic [XLEN-1:0] q_rd  [$];
  logic            q_ill [$];
  logic [XLEN-1:0] q_wr  [$];

  // Bench-side model of the two stores
  logic [XLEN-1:0] m_usr;
  logic [XLEN-1:0] m_sup;

  always #2.5 clk = ~clk;

  cap_csr_bank #(.XLEN(XLEN)) dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .csr_addr (csr_addr),
    .cur_priv (cur_priv),
    .rd_en    (rd_en),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .rd_data  (rd_data),
    .illegal  (illegal),
    .wr_result(wr_result)
  );

  function automatic bit spec_defined(logic [11:0] a, logic [1:0] p);
    if (a == 12'h8C0) return 1'b1;
    if (a == 12'h9C0) return (p == PM) || (p == PS);
    if (a == 12'hBC0) return (p == PM);
    return 1'b0;
  endfunction

  task automatic access(string tag, logic [11:0] a, logic [1:0] p,
                        logic rd, logic wr, logic [XLEN-1:0] d);
    bit              def;
    bit              use_usr;
    logic [XLEN-1:0] old_v;
    logic [XLEN-1:0] new_v;
    @(negedge clk);
    csr_addr = a;
    cur_priv = p;
    rd_en    = rd;
    wr_en    = wr;
    wr_data  = d;
    def      = spec_defined(a, p);
    use_usr  = (a == 12'h8C0);
    old_v    = use_usr ? m_usr : m_sup;
    new_v    = {old_v[XLEN-1:2], 2'b11};
    q_tag.push_back(tag);
    q_rd.push_back((rd && def) ? old_v : '0);
    q_ill.push_back((rd || wr) && !def);
    q_wr.push_back((wr && def) ? new_v : '0);
    if (wr && def) begin
      if (use_usr) m_usr = new_v;
      else         m_sup = new_v;
    end
  endtask

  // Monitor
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (q_tag.size() > 0) begin
        string           t;
        logic [XLEN-1:0] er;
        logic            ei;
        logic [XLEN-1:0] ew;
        t  = q_tag.pop_front();
        er = q_rd.pop_front();
        ei = q_ill.pop_front();
        ew = q_wr.pop_front();
        compared++;
        if (rd_data !== er || illegal !== ei || wr_result !== ew) begin
          mismatched++;
          $display("FAIL %s: rd_data=%h illegal=%b wr_result=%h expected rd_data=%h illegal=%b wr_result=%h",
                   t, rd_data, illegal, wr_result, er, ei, ew);
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog: run hung, actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    m_usr = 64'h3;
    m_sup = 64'h3;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    access("R3 reset value user",        12'h8C0, PU, 1, 0, '0);
    access("R1 read supervisor",         12'h9C0, PM, 1, 0, '0);
    access("R4 write user zeros",        12'h8C0, PU, 0, 1, '0);
    access("R5 write user ones",         12'h8C0, PU, 0, 1, '1);
    access("R6 read back user",          12'h8C0, PU, 1, 0, '0);
    access("R2 write machine window",    12'hBC0, PM, 0, 1, 64'hA5A5_0000_FFFF_0000);
    access("R2 read machine window",     12'hBC0, PM, 1, 0, '0);
    access("R8 supervisor at user",      12'h9C0, PU, 1, 0, '0);
    access("R8 supervisor at reserved",  12'h9C0, PR, 1, 1, '1);
    access("R8 write supervisor at S",   12'h9C0, PS, 1, 1, 64'hFFFF_FFFF_FFFF_FFFC);
    access("R6 read supervisor after",   12'h9C0, PS, 1, 0, '0);
    access("R9 machine window at S",     12'hBC0, PS, 1, 0, '0);
    access("R9 machine window at U",     12'hBC0, PU, 0, 1, '1);
    access("R7 user at S",               12'h8C0, PS, 1, 0, '0);
    access("R7 user at M",               12'h8C0, PM, 1, 1, 64'h1234);
    access("R10 unknown address read",   12'h7C0, PM, 1, 0, '0);
    access("R10 unknown address write",  12'h123, PM, 0, 1, '1);
    access("R10 storage kept sup",       12'hBC0, PM, 1, 0, '0);
    access("R10 storage kept usr",       12'h8C0, PU, 1, 0, '0);
    access("R10 idle no strobe",         12'h456, PU, 0, 0, '1);
    access("R1 idle at defined address", 12'h8C0, PU, 0, 0, '0);

    repeat (3) @(negedge clk);
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule